// File: doc/BRIEF.md
# USB Host Controller Suspend Wake-up Sequencer

This block decides when the internal clock of a USB host controller may run while the controller is suspended. It runs on a free-running reference clock that is never gated. It drives a clock-enable output that is low only in the suspend state. It also tracks a four-state controller mode: operational, suspend, resume and waking.

Three paths bring the clock back, in parallel. The first is a dedicated wake-up pin: the pin must stay high for a fixed delay before the clock comes up, and once up, the clock drops again only after the pin has stayed low longer than a separate, longer timeout. The second is a chip-select from the host processor, which wakes the clock at once. The third is a qualified resume indication from a downstream device, which moves the controller into the resume state and latches a resume-detected status bit. That status bit drives an interrupt output through an enable bit.

The processor reaches the block through a byte-wide command port. A read command code selects a register onto a combinational read bus. The matching write code is the read code with bit 7 set. Write commands take effect only while the clock-enable is high. Delays are parameters derived from the reference clock frequency: 160 µs for wake-up and 1.14 ms for the drop-back.

Top module: `hc_wake_seq`

## Requirements
- R1: After reset the clock-enable is high, the control register reads mode code 2'b10 (operational) in bits [1:0], the status register reads 0 and the interrupt output is low.
- R2: Writing code 2'b11 into control bits [1:0] (command 81h) while the clock-enable is high enters suspend, and the clock-enable is low after that clock edge.
- R3: In suspend, the clock-enable rises on the T_UP-th consecutive reference edge that samples the wake-up pin high, and not earlier. T_UP is REF_HZ*160/1e6, and the block then reads mode code 2'b00 (waking).
- R4: A wake-up pin pulse shorter than T_UP cycles leaves the clock-enable low, and the next rising edge of the pin starts the count from zero.
- R5: In the waking state the clock-enable stays high while the pin is high. Once the pin is low, the block returns to suspend on the (T_DN+1)-th consecutive low-sampled edge, where T_DN is REF_HZ*1140/1e6. After T_DN low edges it is still awake.
- R6: A chip-select in suspend raises the clock-enable after the next edge and enters the waking state (code 2'b00).
- R7: A bus-resume indication in suspend enters the resume state (code 2'b01), raises the clock-enable and sets status bit 6. It takes priority over a chip-select in the same cycle.
- R8: Writing status (command 83h) with data bit 6 = 1 clears status bit 6; data bit 6 = 0 leaves it unchanged.
- R9: The interrupt output equals status bit 6 AND enable bit 6. The enable register is read at 04h and written at 84h, and only bit 6 is stored.
- R10: Every write command made while the clock-enable is low is ignored, including a write of the operational code.
- R11: Writing code 2'b10 to the control register from the waking or resume state returns the block to operational. The resume state has no timeout.
- R12: Read codes are 01h (control), 03h (status) and 04h (enable), and each write code is its read code with bit 7 set. Write command 81h with a code other than 2'b10 or 2'b11, and commands without bit 7 set, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| wakePin | input | 1 | Wake-up pin, synchronous to clk |
| chipSel | input | 1 | Processor chip-select (software wake-up) |
| busResume | input | 1 | Qualified resume indication from the root port |
| cmdValid | input | 1 | Command strobe |
| cmdCode | input | 8 | Command code; bit 7 marks a write |
| cmdData | input | DATA_W | Write data |
| rdData | output | DATA_W | Register selected by cmdCode (combinational) |
| clkEn | output | 1 | Internal clock-enable |
| irq | output | 1 | Interrupt request to the processor |

## Verification
A wrong mode register shows at clkEn and in the control read code on the edge right after the stimulus. A wrong timer count shows as clkEn moving one or more cycles away from the T_UP-th high edge or the (T_DN+1)-th low edge. The bench sweeps every pulse length below T_UP and samples exactly at both of those boundaries. A faulty status or enable latch appears on irq and on rdData within one command, and the bench sweeps every write-data byte through both registers.

// File: rtl/hc_wake_pkg.sv
`timescale 1ns/1ps
package hc_wake_pkg;

  typedef enum logic [1:0] {
    ST_OPER   = 2'd0,
    ST_SUSP   = 2'd1,
    ST_RESUME = 2'd2,
    ST_WAKING = 2'd3
  } wake_state_e;

  // control -> datapath
  typedef struct packed {
    logic upRun;
    logic dnRun;
    logic setResume;
    logic gateOn;
  } wake_strobe_t;

  // datapath -> control
  typedef struct packed {
    logic upDone;
    logic dnExpired;
    logic goOper;
    logic goSusp;
  } wake_flag_t;

  localparam logic [1:0] CODE_OPER   = 2'b10;
  localparam logic [1:0] CODE_SUSP   = 2'b11;
  localparam logic [1:0] CODE_RESUME = 2'b01;
  localparam logic [1:0] CODE_WAKING = 2'b00;

  localparam logic [6:0] ADDR_CTRL = 7'h01;
  localparam logic [6:0] ADDR_STAT = 7'h03;
  localparam logic [6:0] ADDR_IEN  = 7'h04;

  localparam int RESUME_BIT = 6;

  function automatic logic [1:0] modeCode(input wake_state_e s);
    case (s)
      ST_OPER:   modeCode = CODE_OPER;
      ST_SUSP:   modeCode = CODE_SUSP;
      ST_RESUME: modeCode = CODE_RESUME;
      default:   modeCode = CODE_WAKING;
    endcase
  endfunction

endpackage

// File: rtl/hc_wake_ctrl.sv
`timescale 1ns/1ps
module hc_wake_ctrl
  import hc_wake_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         wakePin,
  input  logic         chipSel,
  input  logic         busResume,
  input  wake_flag_t   flags,
  output wake_state_e  state,
  output wake_strobe_t strb
);

  wake_state_e stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_OPER: begin
        if (flags.goSusp) stateNext = ST_SUSP;
      end
      ST_SUSP: begin
        if (busResume)         stateNext = ST_RESUME;
        else if (chipSel)      stateNext = ST_WAKING;
        else if (flags.upDone) stateNext = ST_WAKING;
      end
      ST_WAKING: begin
        if (flags.goOper)         stateNext = ST_OPER;
        else if (flags.goSusp)    stateNext = ST_SUSP;
        else if (flags.dnExpired) stateNext = ST_SUSP;
      end
      ST_RESUME: begin
        if (flags.goOper)      stateNext = ST_OPER;
        else if (flags.goSusp) stateNext = ST_SUSP;
      end
      default: stateNext = ST_OPER;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_OPER;
    else       state <= stateNext;
  end

  always_comb begin
    strb.upRun     = (state == ST_SUSP);
    strb.dnRun     = (state == ST_WAKING);
    strb.setResume = (state == ST_SUSP) && busResume;
    strb.gateOn    = (state != ST_SUSP);
  end

  p_susp_entry_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OPER && flags.goSusp) |=> (state == ST_SUSP));

  p_no_early_wake_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SUSP && !busResume && !chipSel && !flags.upDone) |=> (state == ST_SUSP));

  p_cs_wake_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SUSP && chipSel && !busResume) |=> (state == ST_WAKING));

  p_resume_prio_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SUSP && busResume) |=> (state == ST_RESUME));

  p_pin_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAKING && wakePin && !flags.goSusp) |=> (state != ST_SUSP));

  p_resume_stay_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RESUME && !flags.goOper && !flags.goSusp) |=> (state == ST_RESUME));

endmodule

// File: rtl/hc_wake_dp.sv
`timescale 1ns/1ps
module hc_wake_dp
  import hc_wake_pkg::*;
#(
  parameter int unsigned REF_HZ = 12_000_000,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wakePin,
  input  logic              chipSel,
  input  logic              cmdValid,
  input  logic [7:0]        cmdCode,
  input  logic [DATA_W-1:0] cmdData,
  input  wake_strobe_t      strb,
  input  wake_state_e       state,
  output wake_flag_t        flags,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);

  localparam longint T_UP_L = (longint'(REF_HZ) * 160) / 1000000;
  localparam longint T_DN_L = (longint'(REF_HZ) * 1140) / 1000000;
  localparam int unsigned T_UP = (T_UP_L < 1) ? 1 : int'(T_UP_L);
  localparam int unsigned T_DN = (T_DN_L < 1) ? 1 : int'(T_DN_L);
  localparam int UP_W = $clog2(T_UP + 1);
  localparam int DN_W = $clog2(T_DN + 2);

  logic [UP_W-1:0] upCnt;
  logic [DN_W-1:0] dnCnt;
  logic            resumeDet;
  logic            ienBit;

  logic       isWr;
  logic [6:0] addr;
  logic       wrEn;
  logic       ctrlWr;
  logic       statWr;
  logic       ienWr;

  assign isWr   = cmdCode[7];
  assign addr   = cmdCode[6:0];
  assign wrEn   = cmdValid && isWr && strb.gateOn;
  assign ctrlWr = wrEn && (addr == ADDR_CTRL);
  assign statWr = wrEn && (addr == ADDR_STAT);
  assign ienWr  = wrEn && (addr == ADDR_IEN);

  // wake-up delay timer: counts consecutive high samples in suspend
  always_ff @(posedge clk) begin
    if (!rstN || !strb.upRun || !wakePin) upCnt <= '0;
    else if (upCnt != UP_W'(T_UP)) upCnt <= upCnt + 1'b1;
  end

  // drop-back timer: counts consecutive low samples while waking
  always_ff @(posedge clk) begin
    if (!rstN || !strb.dnRun || wakePin || chipSel) dnCnt <= '0;
    else if (dnCnt != DN_W'(T_DN)) dnCnt <= dnCnt + 1'b1;
  end

  always_comb begin
    flags.upDone    = strb.upRun && wakePin && (upCnt == UP_W'(T_UP - 1));
    flags.dnExpired = strb.dnRun && !wakePin && !chipSel && (dnCnt == DN_W'(T_DN));
    flags.goOper    = ctrlWr && (cmdData[1:0] == CODE_OPER);
    flags.goSusp    = ctrlWr && (cmdData[1:0] == CODE_SUSP);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                resumeDet <= 1'b0;
    else if (strb.setResume)                  resumeDet <= 1'b1;
    else if (statWr && cmdData[RESUME_BIT])   resumeDet <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)      ienBit <= 1'b0;
    else if (ienWr) ienBit <= cmdData[RESUME_BIT];
  end

  always_comb begin
    rdData = '0;
    if (!isWr) begin
      case (addr)
        ADDR_CTRL: rdData[1:0] = modeCode(state);
        ADDR_STAT: rdData[RESUME_BIT] = resumeDet;
        ADDR_IEN:  rdData[RESUME_BIT] = ienBit;
        default:   rdData = '0;
      endcase
    end
  end

  assign irq = resumeDet && ienBit;

  p_resume_latch_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.setResume |=> resumeDet);

  p_w1c_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (statWr && cmdData[RESUME_BIT] && !strb.setResume) |=> !resumeDet);

  p_w0_keep_r8: assert property (@(posedge clk) disable iff (!rstN)
    (resumeDet && !(statWr && cmdData[RESUME_BIT])) |=> resumeDet);

  p_gated_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.gateOn |=> $stable(ienBit));

  p_up_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!wakePin) |=> (upCnt == '0));

endmodule

// File: rtl/hc_wake_seq.sv
`timescale 1ns/1ps
module hc_wake_seq
  import hc_wake_pkg::*;
#(
  parameter int unsigned REF_HZ = 12_000_000,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wakePin,
  input  logic              chipSel,
  input  logic              busResume,
  input  logic              cmdValid,
  input  logic [7:0]        cmdCode,
  input  logic [DATA_W-1:0] cmdData,
  output logic [DATA_W-1:0] rdData,
  output logic              clkEn,
  output logic              irq
);

  wake_state_e  state;
  wake_strobe_t strb;
  wake_flag_t   flags;

  hc_wake_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .wakePin   (wakePin),
    .chipSel   (chipSel),
    .busResume (busResume),
    .flags     (flags),
    .state     (state),
    .strb      (strb)
  );

  hc_wake_dp #(
    .REF_HZ (REF_HZ),
    .DATA_W (DATA_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .wakePin  (wakePin),
    .chipSel  (chipSel),
    .cmdValid (cmdValid),
    .cmdCode  (cmdCode),
    .cmdData  (cmdData),
    .strb     (strb),
    .state    (state),
    .flags    (flags),
    .rdData   (rdData),
    .irq      (irq)
  );

  assign clkEn = strb.gateOn;

endmodule

// File: tb/hc_wake_seq_tb_top.sv
`timescale 1ns/1ps
module hc_wake_seq_tb_top;

  localparam int REF_HZ = 100_000;
  localparam int TUP = REF_HZ * 160 / 1_000_000;
  localparam int TDN = REF_HZ * 1140 / 1_000_000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wakePin = 1'b0;
  logic       chipSel = 1'b0;
  logic       busResume = 1'b0;
  logic       cmdValid = 1'b0;
  logic [7:0] cmdCode = 8'h00;
  logic [7:0] cmdData = 8'h00;
  logic [7:0] rdData;
  logic       clkEn;
  logic       irq;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  hc_wake_seq #(.REF_HZ(REF_HZ), .DATA_W(8)) dut_i (
    .clk(clk), .rstN(rstN), .wakePin(wakePin), .chipSel(chipSel),
    .busResume(busResume), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .cmdData(cmdData), .rdData(rdData), .clkEn(clkEn), .irq(irq)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] c, output logic [7:0] v);
    cmdValid = 1'b0;
    cmdCode  = c;
    #1;
    v = rdData;
  endtask

  task automatic wr(input logic [7:0] c, input logic [7:0] d);
    cmdCode  = c;
    cmdData  = d;
    cmdValid = 1'b1;
    step(1);
    cmdValid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    step(3);
    rstN = 1'b1;
    step(1);

    // R1 reset state
    chk("R1 clkEn", clkEn, 1);
    rd(8'h01, v); chk("R1 ctrl", v, 8'h02);
    rd(8'h03, v); chk("R1 status", v, 8'h00);
    chk("R1 irq", irq, 0);

    // R9 / R12 enable register
    wr(8'h84, 8'hFF);
    rd(8'h04, v); chk("R9 ien read", v, 8'h40);

    // R2 suspend entry
    wr(8'h81, 8'h03);
    chk("R2 clkEn", clkEn, 0);
    rd(8'h01, v); chk("R2 ctrl", v, 8'h03);

    // R10 writes ignored while gated
    wr(8'h84, 8'h00);
    wr(8'h81, 8'h02);
    chk("R10 clkEn", clkEn, 0);
    rd(8'h04, v); chk("R10 ien", v, 8'h40);
    rd(8'h01, v); chk("R10 ctrl", v, 8'h03);

    // R4 sweep of short pulses
    for (int len = 1; len < TUP; len++) begin
      wakePin = 1'b1;
      step(len);
      chk("R4 short pulse high", clkEn, 0);
      wakePin = 1'b0;
      step(1);
      chk("R4 short pulse low", clkEn, 0);
    end

    // R3 exact wake-up boundary
    wakePin = 1'b1;
    step(TUP - 1);
    chk("R3 before delay", clkEn, 0);
    step(1);
    chk("R3 at delay", clkEn, 1);
    rd(8'h01, v); chk("R3 waking code", v, 8'h00);

    // R5 hold while high, drop after timeout
    step(200);
    chk("R5 hold high", clkEn, 1);
    wakePin = 1'b0;
    step(TDN);
    chk("R5 before timeout", clkEn, 1);
    step(1);
    chk("R5 after timeout", clkEn, 0);
    rd(8'h01, v); chk("R5 ctrl", v, 8'h03);

    // R6 chip-select wake
    chipSel = 1'b1;
    step(1);
    chipSel = 1'b0;
    chk("R6 clkEn", clkEn, 1);
    rd(8'h01, v); chk("R6 ctrl", v, 8'h00);

    // R11 back to operational
    wr(8'h81, 8'h02);
    rd(8'h01, v); chk("R11 oper from waking", v, 8'h02);

    // R7 bus resume with priority over chip-select
    wr(8'h81, 8'h03);
    busResume = 1'b1;
    chipSel   = 1'b1;
    step(1);
    busResume = 1'b0;
    chipSel   = 1'b0;
    chk("R7 clkEn", clkEn, 1);
    rd(8'h01, v); chk("R7 ctrl", v, 8'h01);
    rd(8'h03, v); chk("R7 status", v, 8'h40);
    chk("R9 irq set", irq, 1);
    step(TDN + 50);
    rd(8'h01, v); chk("R11 resume no timeout", v, 8'h01);

    // R8 write-one-to-clear
    wr(8'h83, 8'hBF);
    rd(8'h03, v); chk("R8 write zero keeps", v, 8'h40);
    wr(8'h83, 8'h40);
    rd(8'h03, v); chk("R8 write one clears", v, 8'h00);
    chk("R9 irq clear", irq, 0);
    wr(8'h81, 8'h02);
    rd(8'h01, v); chk("R11 oper from resume", v, 8'h02);

    // R12 non-operational codes and read codes change nothing
    wr(8'h81, 8'h01);
    rd(8'h01, v); chk("R12 resume code ignored", v, 8'h02);
    wr(8'h81, 8'h00);
    rd(8'h01, v); chk("R12 zero code ignored", v, 8'h02);
    wr(8'h01, 8'h03);
    chk("R12 read code no write", clkEn, 1);
    rd(8'h83, v); chk("R12 write code reads zero", v, 8'h00);

    // R8 / R9 sweep over every data byte
    for (int d = 0; d < 256; d++) begin
      wr(8'h84, 8'(d));
      rd(8'h04, v); chk("R9 ien sweep", v, 8'(d) & 8'h40);
      wr(8'h81, 8'h03);
      busResume = 1'b1;
      step(1);
      busResume = 1'b0;
      chk("R9 irq sweep", irq, (d >> 6) & 1);
      wr(8'h83, 8'(d));
      rd(8'h03, v); chk("R8 w1c sweep", v, ((d >> 6) & 1) ? 8'h00 : 8'h40);
      wr(8'h81, 8'h02);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule